// File: doc/BRIEF.md
# DMA Channel Run-Control and Interrupt Register Bank

This block holds the software-visible run control and interrupt state for a multi-channel, descriptor-driven DMA engine. Each channel owns a pair of registers in a fixed-stride window. The first is the address of the first descriptor of the chain, which software writes before starting the channel. The second is a semaphore that counts outstanding descriptors. Software starts work by adding to the semaphore. The engine removes one from the count each time a descriptor completes. The channel asks to run for as long as its count is nonzero. Software learns that the chain has finished by polling the count until it reads zero.

Two shared registers collect events from every channel. The completion register holds one flag per channel, set by the engine's command-done pulse, next to a per-channel interrupt enable. The error register holds one flag per channel and a second bit per channel that tells a bus error from a termination. A single interrupt line combines the enabled completion flags with all error flags. A per-channel reset input returns one channel's counter and event state to idle.

Top module: `dma_sema_irq_regs`

## Requirements
- R1: After rst_n is low, every register reads zero, run_req_o is all zero and irq_o is 0.
- R2: Channel n's descriptor address register sits at 0x100 + n*0x70. It is read and written as 32 bits, and its value appears on cmd_addr_o[n*32 +: 32].
- R3: A write to the semaphore register at 0x104 + n*0x70 adds wdata_i[7:0] to channel n's 8-bit count, saturating at 255. A read of that register returns the count in bits [23:16], with all other bits 0. run_req_o[n] is 1 exactly when the count is nonzero.
- R4: A sema_dec_i[n] pulse removes 1 from the count and never takes it below 0. When an increment write and a decrement pulse arrive in the same cycle, the count changes by the difference of the two.
- R5: A done_i[n] pulse sets completion flag bit n of the register at 0x000. Writing 1 to bit n at 0x008 (clear alias) clears the flag. Writing 1 to bit n at 0x004 (set alias) sets it.
- R6: When a done_i[n] pulse and a clear-alias write of bit n fall in the same cycle, the flag ends up set.
- R7: Bit 16+n of 0x000 is channel n's completion interrupt enable, changed through the set and clear aliases. irq_o is 1 when any completion flag has its enable set, or when any error flag is set.
- R8: A term_i[n] pulse sets error bit n of the register at 0x010 and makes bit 16+n equal to 0. A buserr_i[n] pulse sets bit n and makes bit 16+n equal to 1. Writing 1 to bits n and 16+n at 0x018 clears them.
- R9: A chan_rst_i[n] pulse clears channel n's count, its completion flag and both of its error bits. Its enable and its descriptor address are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| done_i | input | NCH | Per-channel command-done pulse |
| buserr_i | input | NCH | Per-channel bus-error pulse |
| term_i | input | NCH | Per-channel termination pulse |
| sema_dec_i | input | NCH | Per-channel descriptor-finished decrement |
| chan_rst_i | input | NCH | Per-channel reset pulse |
| run_req_o | output | NCH | Per-channel run request |
| cmd_addr_o | output | NCH*32 | Per-channel first-descriptor address |
| irq_o | output | 1 | Combined interrupt |

## Verification
Same-cycle collisions are the hardest cases to reach from the ports. These are a done pulse meeting a clear write on the same bit, an increment write meeting a decrement pulse, and a channel reset meeting pending state. The bench drives the write strobe and the engine pulses in the same cycle on purpose to create each of them. It also drives the count to both saturation limits, 255 and 0, and checks that a reset on one channel leaves that channel's enable and address intact.

// File: rtl/dma_sema_irq_regs.sv
module dma_sema_irq_regs #(
  parameter int NCH       = 8,
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 8,
  parameter int CHAN_BASE = 'h100,
  parameter int STRIDE    = 'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NCH-1:0]    done_i,
  input  logic [NCH-1:0]    buserr_i,
  input  logic [NCH-1:0]    term_i,
  input  logic [NCH-1:0]    sema_dec_i,
  input  logic [NCH-1:0]    chan_rst_i,
  output logic [NCH-1:0]    run_req_o,
  output logic [NCH*32-1:0] cmd_addr_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_IRQ     = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_IRQ_SET = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_ERR     = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_ERR_CLR = ADDR_W'('h018);
  localparam logic [CNT_W:0]    CNT_MAX   = (CNT_W+1)'((1 << CNT_W) - 1);

  logic [NCH-1:0] cmplt_q, en_q, err_q, etype_q;
  logic [NCH-1:0] cmplt_d, en_d, err_d, etype_d;
  logic [CNT_W-1:0] cnt_q [NCH];
  logic [31:0]      cmd_q [NCH];

  wire [NCH-1:0] lo = wdata_i[NCH-1:0];
  wire [NCH-1:0] hi = wdata_i[16 +: NCH];
  wire wr_irq     = wr_en_i && addr_i == A_IRQ;
  wire wr_irq_set = wr_en_i && addr_i == A_IRQ_SET;
  wire wr_irq_clr = wr_en_i && addr_i == A_IRQ_CLR;
  wire wr_err_clr = wr_en_i && addr_i == A_ERR_CLR;
  wire [NCH-1:0] any_err = buserr_i | term_i;

  always_comb begin
    en_d    = wr_irq ? hi : wr_irq_set ? (en_q | hi) : wr_irq_clr ? (en_q & ~hi) : en_q;
    cmplt_d = wr_irq ? lo : wr_irq_set ? (cmplt_q | lo) : wr_irq_clr ? (cmplt_q & ~lo) : cmplt_q;
    cmplt_d = (cmplt_d | done_i) & ~chan_rst_i;
    err_d   = wr_err_clr ? (err_q & ~lo) : err_q;
    err_d   = (err_d | any_err) & ~chan_rst_i;
    etype_d = wr_err_clr ? (etype_q & ~hi) : etype_q;
    etype_d = ((etype_d & ~any_err) | buserr_i) & ~chan_rst_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmplt_q <= '0;
      en_q    <= '0;
      err_q   <= '0;
      etype_q <= '0;
    end else begin
      cmplt_q <= cmplt_d;
      en_q    <= en_d;
      err_q   <= err_d;
      etype_q <= etype_d;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CHAN_BASE + n * STRIDE);
    localparam logic [ADDR_W-1:0] A_SEMA = ADDR_W'(CHAN_BASE + n * STRIDE + 4);
    logic [CNT_W:0]   up, down;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
      up    = {1'b0, cnt_q[n]} +
              ((wr_en_i && addr_i == A_SEMA) ? {1'b0, wdata_i[CNT_W-1:0]} : '0);
      down  = (sema_dec_i[n] && up != '0) ? up - 1'b1 : up;
      cnt_d = (down > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : down[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[n] <= '0;
        cmd_q[n] <= '0;
      end else begin
        cnt_q[n] <= chan_rst_i[n] ? '0 : cnt_d;
        if (wr_en_i && addr_i == A_CMD) cmd_q[n] <= wdata_i;
      end
    end

    assign run_req_o[n]          = cnt_q[n] != '0;
    assign cmd_addr_o[n*32 +: 32] = cmd_q[n];
  end

  assign irq_o = (|(cmplt_q & en_q)) | (|err_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_IRQ || addr_i == A_IRQ_SET || addr_i == A_IRQ_CLR) begin
      rdata_o[NCH-1:0]  = cmplt_q;
      rdata_o[16 +: NCH] = en_q;
    end
    if (addr_i == A_ERR || addr_i == A_ERR_CLR) begin
      rdata_o[NCH-1:0]  = err_q;
      rdata_o[16 +: NCH] = etype_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(CHAN_BASE + i * STRIDE)) rdata_o = cmd_q[i];
      if (addr_i == ADDR_W'(CHAN_BASE + i * STRIDE + 4)) rdata_o[16 +: CNT_W] = cnt_q[i];
    end
  end
endmodule

// File: rtl/dma_sema_irq_regs_chk.sv
module dma_sema_irq_regs_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en_i,
  input logic [NCH-1:0] done_i,
  input logic [NCH-1:0] buserr_i,
  input logic [NCH-1:0] term_i,
  input logic [NCH-1:0] sema_dec_i,
  input logic [NCH-1:0] chan_rst_i,
  input logic [NCH-1:0] run_req_o,
  input logic           irq_o,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] cmplt_q
);
  assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && |(done_i & ~chan_rst_i & en_q)) |=> irq_o);

  assert_err_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|((buserr_i | term_i) & ~chan_rst_i)) |=> irq_o);

  assert_chan_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_rst_i) |=> ((run_req_o & $past(chan_rst_i)) == '0));

  assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(run_req_o & ~chan_rst_i & ~sema_dec_i)) |=>
      (($past(run_req_o & ~chan_rst_i & ~sema_dec_i) & ~run_req_o) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_i) |=> (($past(done_i & ~chan_rst_i) & ~cmplt_q) == '0));
endmodule

bind dma_sema_irq_regs dma_sema_irq_regs_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_sema_irq_regs_bench.sv
module dma_sema_irq_regs_bench;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] done = '0, buserr = '0, term = '0, dec = '0, crst = '0, run_req;
  logic [NCH*32-1:0] cmd_addr;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_sema_irq_regs u_dma_sema_irq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_i(done), .buserr_i(buserr), .term_i(term),
    .sema_dec_i(dec), .chan_rst_i(crst), .run_req_o(run_req),
    .cmd_addr_o(cmd_addr), .irq_o(irq));

  function automatic logic [11:0] cmd_a(int n);  return 12'(32'h100 + n * 32'h70); endfunction
  function automatic logic [11:0] sema_a(int n); return 12'(32'h104 + n * 32'h70); endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 0; done = '0; buserr = '0; term = '0; dec = '0; crst = '0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); check("R1 irq reg", v, 0);
    rd(12'h010, v); check("R1 err reg", v, 0);
    rd(sema_a(0), v); check("R1 sema0", v, 0);
    check("R1 run_req", 32'(run_req), 0);
    check("R1 irq_o", 32'(irq), 0);
  endtask

  task automatic t_cmdaddr();
    logic [31:0] v;
    wr(cmd_a(0), 32'h8000_1000);
    wr(cmd_a(7), 32'hCAFE_0040);
    rd(cmd_a(0), v); check("R2 ch0 read", v, 32'h8000_1000);
    rd(cmd_a(7), v); check("R2 ch7 read", v, 32'hCAFE_0040);
    check("R2 ch7 port", cmd_addr[7*32 +: 32], 32'hCAFE_0040);
    check("R2 ch3 untouched", cmd_addr[3*32 +: 32], 0);
  endtask

  task automatic t_sema();
    logic [31:0] v;
    wr(sema_a(2), 32'd3);
    rd(sema_a(2), v); check("R3 count 3", v, 32'h0003_0000);
    check("R3 run_req2", 32'(run_req[2]), 1);
    wr(sema_a(2), 32'hFFFF_FFFF);
    rd(sema_a(2), v); check("R3 saturate 255", v, 32'h00FF_0000);
    crst[2] = 1; step();
  endtask

  task automatic t_dec();
    logic [31:0] v;
    wr(sema_a(1), 32'd2);
    dec[1] = 1; step();
    dec[1] = 1; step();
    rd(sema_a(1), v); check("R4 down to 0", v, 0);
    check("R4 run_req1 off", 32'(run_req[1]), 0);
    dec[1] = 1; step();
    rd(sema_a(1), v); check("R4 floor 0", v, 0);
    dec[1] = 1; wr(sema_a(1), 32'd5);
    rd(sema_a(1), v); check("R4 inc+dec", v, 32'h0004_0000);
    crst[1] = 1; step();
  endtask

  task automatic t_cmplt();
    logic [31:0] v;
    done[3] = 1; step();
    rd(12'h000, v); check("R5 flag set", v, 32'h0000_0008);
    check("R7 masked irq", 32'(irq), 0);
    wr(12'h004, 32'h0008_0000);
    rd(12'h000, v); check("R7 enable bit19", v, 32'h0008_0008);
    check("R7 irq on", 32'(irq), 1);
    wr(12'h008, 32'h0000_0008);
    rd(12'h000, v); check("R5 flag cleared", v, 32'h0008_0000);
    check("R7 irq off", 32'(irq), 0);
    wr(12'h004, 32'h0000_0001);
    rd(12'h000, v); check("R5 set alias", v, 32'h0008_0001);
    wr(12'h008, 32'h0008_0001);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    done[4] = 1; wr(12'h008, 32'h0000_0010);
    rd(12'h000, v); check("R6 set beats clear", v, 32'h0000_0010);
    wr(12'h008, 32'h0000_0010);
  endtask

  task automatic t_err();
    logic [31:0] v;
    term[5] = 1; step();
    rd(12'h010, v); check("R8 termination", v, 32'h0000_0020);
    check("R8 irq", 32'(irq), 1);
    buserr[5] = 1; step();
    rd(12'h010, v); check("R8 bus error", v, 32'h0020_0020);
    term[5] = 1; step();
    rd(12'h010, v); check("R8 type back to 0", v, 32'h0000_0020);
    wr(12'h018, 32'h0020_0020);
    rd(12'h010, v); check("R8 cleared", v, 0);
    check("R8 irq off", 32'(irq), 0);
  endtask

  task automatic t_chrst();
    logic [31:0] v;
    wr(cmd_a(6), 32'h1234_5678);
    wr(sema_a(6), 32'd4);
    wr(12'h004, 32'h0040_0000);
    done[6] = 1; buserr[6] = 1; step();
    check("R9 pre irq", 32'(irq), 1);
    crst[6] = 1; step();
    rd(sema_a(6), v); check("R9 count cleared", v, 0);
    rd(12'h000, v); check("R9 flag cleared, enable kept", v, 32'h0040_0000);
    rd(12'h010, v); check("R9 error cleared", v, 0);
    rd(cmd_a(6), v); check("R9 address kept", v, 32'h1234_5678);
    check("R9 irq off", 32'(irq), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cmdaddr();
    t_sema();
    t_dec();
    t_cmplt();
    t_set_wins();
    t_err();
    t_chrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule